// File: doc/BRIEF.md
# Startup Boot Target Selector

This block decides, once per reset, which memory region the processor fetches its first instructions from: main flash, system memory, or embedded SRAM. Its inputs are a dedicated boot pin, three option bits, and the first word read from main flash together with a flag that says whether that word is valid. One option bit picks where the primary boot value comes from. It can come from the pin or from an option bit, so a board that needs the pin for general I/O can still choose a boot region.

On the first clock edge after reset is released, the selector captures its inputs and decodes them. It registers a two-bit target and raises a one-cycle strobe that tells the interconnect the remap is ready. If the decode lands on main flash but that flash looks erased, the selector sends the processor to system memory instead, where a loader can program the part. After the strobe, the target stays frozen until the next reset.

Top module: `boot_select`

## Requirements
- R1: While `rst` is high, `boot_target` is 2'b00 (main flash) and `boot_valid` is low.
- R2: `boot_valid` is high for exactly one cycle, which is the cycle after the first rising clock edge at which `rst` is low. It stays low after that until the next reset.
- R3: The primary boot value is `boot_pin` when `opt_b0_from_opt` is 0 and `opt_boot0` when `opt_b0_from_opt` is 1. The input that is not selected has no effect on `boot_target`.
- R4: If the primary boot value is 0, the target is main flash (2'b00), whatever `opt_boot1` is, provided flash is not erased.
- R5: If the primary boot value is 1 and `opt_boot1` is 1, the target is system memory (2'b01).
- R6: If the primary boot value is 1 and `opt_boot1` is 0, the target is embedded SRAM (2'b10).
- R7: If the decode gives main flash, `flash_word_valid` is 1 and `flash_word` is all ones, the target is system memory (2'b01).
- R8: When `flash_word` is not all ones, or when `flash_word_valid` is 0, the erased-flash override does not apply and main flash stays selected.
- R9: The erased-flash condition does not change a system-memory or SRAM decode.
- R10: After the strobe, `boot_target` holds its value through any change of the inputs until `rst` is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pin | input | 1 | External boot pin level |
| opt_b0_from_opt | input | 1 | Option bit: 1 takes the primary boot value from `opt_boot0`, 0 takes it from `boot_pin` |
| opt_boot0 | input | 1 | Option-bit form of the primary boot value |
| opt_boot1 | input | 1 | Option bit giving the secondary boot value |
| flash_word | input | WORD_W | First word of main flash |
| flash_word_valid | input | 1 | `flash_word` holds a real read result |
| boot_target | output | 2 | 00 main flash, 01 system memory, 10 SRAM |
| boot_valid | output | 1 | One-cycle strobe when `boot_target` is decided |

## Verification
The assertions check the timing contract on every cycle:
- the reset defaults;
- the strobe that follows reset release;
- that the strobe never lasts longer than one cycle or comes back;
- that the target stays frozen after the strobe;
- that the captured target agrees with the decode of the inputs from the cycle before.

Only the bench's scenarios show the following:
- that the input not picked by the source-select bit really has no effect;
- that a flash word one bit short of erased, or an erased word flagged invalid, leaves main flash selected;
- that input changes after the decision are ignored.

// File: rtl/boot_select_pkg.sv
package boot_select_pkg;
  typedef enum logic [1:0] {
    TGT_FLASH  = 2'b00,
    TGT_SYSMEM = 2'b01,
    TGT_SRAM   = 2'b10
  } boot_tgt_e;
endpackage

// File: rtl/boot_src_mux.sv
module boot_src_mux (
  input  logic b0_from_opt,
  input  logic pin_level,
  input  logic opt_level,
  output logic primary
);
  always_comb primary = b0_from_opt ? opt_level : pin_level;
endmodule

// File: rtl/boot_decode.sv
module boot_decode
  import boot_select_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              primary,
  input  logic              secondary,
  input  logic [WORD_W-1:0] first_word,
  input  logic              first_word_ok,
  output boot_tgt_e         target
);
  localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};

  logic flash_blank;
  always_comb begin
    flash_blank = first_word_ok && (first_word == ERASED);
    if (!primary)
      target = flash_blank ? TGT_SYSMEM : TGT_FLASH;
    else if (secondary)
      target = TGT_SYSMEM;
    else
      target = TGT_SRAM;
  end
endmodule

// File: rtl/boot_capture.sv
module boot_capture
  import boot_select_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  boot_tgt_e next_tgt,
  output logic [1:0] tgt_q,
  output logic       strobe_q
);
  logic decided;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q    <= TGT_FLASH;
      strobe_q <= 1'b0;
      decided  <= 1'b0;
    end else if (!decided) begin
      tgt_q    <= next_tgt;
      strobe_q <= 1'b1;
      decided  <= 1'b1;
    end else begin
      strobe_q <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_select.sv
module boot_select
  import boot_select_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_pin,
  input  logic              opt_b0_from_opt,
  input  logic              opt_boot0,
  input  logic              opt_boot1,
  input  logic [WORD_W-1:0] flash_word,
  input  logic              flash_word_valid,
  output logic [1:0]        boot_target,
  output logic              boot_valid
);
  logic      primary;
  boot_tgt_e decoded;

  boot_src_mux u_mux (
    .b0_from_opt (opt_b0_from_opt),
    .pin_level   (boot_pin),
    .opt_level   (opt_boot0),
    .primary     (primary)
  );

  boot_decode #(.WORD_W(WORD_W)) u_dec (
    .primary       (primary),
    .secondary     (opt_boot1),
    .first_word    (flash_word),
    .first_word_ok (flash_word_valid),
    .target        (decoded)
  );

  boot_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .next_tgt (decoded),
    .tgt_q    (boot_target),
    .strobe_q (boot_valid)
  );
endmodule

// File: rtl/boot_select_chk.sv
module boot_select_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              boot_pin,
  input logic              opt_b0_from_opt,
  input logic              opt_boot0,
  input logic              opt_boot1,
  input logic [WORD_W-1:0] flash_word,
  input logic              flash_word_valid,
  input logic [1:0]        boot_target,
  input logic              boot_valid
);
  logic pulsed;
  logic eff_b0;
  logic blank;

  always_comb begin
    eff_b0 = opt_b0_from_opt ? opt_boot0 : boot_pin;
    blank  = flash_word_valid && (&flash_word);
  end

  always_ff @(posedge clk) begin
    if (rst) pulsed <= 1'b0;
    else if (boot_valid) pulsed <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (boot_target == 2'b00 && !boot_valid));

  a_r2_pulse_after_release: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> boot_valid);

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    boot_valid |=> !boot_valid);

  a_r2_no_repeat: assert property (@(posedge clk) disable iff (rst)
    pulsed |-> !boot_valid);

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    pulsed |=> $stable(boot_target));

  a_r6_sram: assert property (@(posedge clk) disable iff (rst)
    (eff_b0 && !opt_boot1 && !boot_valid && !pulsed) |=> (boot_target == 2'b10));

  a_r5_sysmem: assert property (@(posedge clk) disable iff (rst)
    (eff_b0 && opt_boot1 && !boot_valid && !pulsed) |=> (boot_target == 2'b01));

  a_r7_blank_override: assert property (@(posedge clk) disable iff (rst)
    (!eff_b0 && blank && !boot_valid && !pulsed) |=> (boot_target == 2'b01));

  a_r4_flash: assert property (@(posedge clk) disable iff (rst)
    (!eff_b0 && !blank && !boot_valid && !pulsed) |=> (boot_target == 2'b00));
endmodule

bind boot_select boot_select_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_boot_select.sv
`timescale 1ns/1ps
module sim_boot_select;
  localparam int W = 32;
  localparam logic [W-1:0] ERASED = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot_pin = 1'b0, opt_b0_from_opt = 1'b0, opt_boot0 = 1'b0, opt_boot1 = 1'b0;
  logic [W-1:0] flash_word = '0;
  logic flash_word_valid = 1'b0;
  logic [1:0] boot_target;
  logic boot_valid;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  boot_select #(.WORD_W(W)) u0 (.*);

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Full boot: set inputs under reset, release, check pulse and target, then disturb inputs.
  task automatic run_boot(input string req, input logic pin, input logic src, input logic ob0,
                          input logic ob1, input logic [W-1:0] word, input logic wv,
                          input logic [1:0] exp);
    @(negedge clk);
    rst = 1'b1;
    boot_pin = pin; opt_b0_from_opt = src; opt_boot0 = ob0; opt_boot1 = ob1;
    flash_word = word; flash_word_valid = wv;
    repeat (3) @(negedge clk);
    chk("R1 reset target", boot_target, 2'b00);
    chk("R1 reset valid", {1'b0, boot_valid}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 strobe high", {1'b0, boot_valid}, 2'b01);
    chk(req, boot_target, exp);
    @(negedge clk);
    chk("R2 strobe one cycle", {1'b0, boot_valid}, 2'b00);
    boot_pin = ~pin; opt_b0_from_opt = ~src; opt_boot0 = ~ob0; opt_boot1 = ~ob1;
    flash_word = ~word; flash_word_valid = ~wv;
    repeat (4) @(negedge clk);
    chk("R10 target frozen", boot_target, exp);
    chk("R2 no second strobe", {1'b0, boot_valid}, 2'b00);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_boot("R4 pin0 flash",           1'b0, 1'b0, 1'b1, 1'b1, 32'h2000_1000, 1'b1, 2'b00);
    run_boot("R5 pin1 sysmem",          1'b1, 1'b0, 1'b0, 1'b1, 32'h2000_1000, 1'b1, 2'b01);
    run_boot("R6 pin1 sram",            1'b1, 1'b0, 1'b0, 1'b0, 32'h2000_1000, 1'b1, 2'b10);
    run_boot("R3 option bit used",      1'b0, 1'b1, 1'b1, 1'b0, 32'h2000_1000, 1'b1, 2'b10);
    run_boot("R3 pin ignored",          1'b1, 1'b1, 1'b0, 1'b1, 32'h2000_1000, 1'b1, 2'b00);
    run_boot("R7 erased flash sysmem",  1'b0, 1'b0, 1'b0, 1'b0, ERASED, 1'b1, 2'b01);
    run_boot("R8 near-erased flash",    1'b0, 1'b0, 1'b0, 1'b0, ERASED ^ 32'h8000_0000, 1'b1, 2'b00);
    run_boot("R8 erased but invalid",   1'b0, 1'b0, 1'b0, 1'b0, ERASED, 1'b0, 2'b00);
    run_boot("R9 erased keeps sram",    1'b1, 1'b0, 1'b0, 1'b0, ERASED, 1'b1, 2'b10);
    run_boot("R9 erased keeps sysmem",  1'b0, 1'b1, 1'b1, 1'b1, ERASED, 1'b1, 2'b01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule